// File: doc/BRIEF.md
# Triggered Delay Pulse Generator

This block waits for a rising edge on one of seven hardware trigger lines and then runs a 16-bit delay counter. The counter advances once every prescaled period. Two compare channels each raise a pulse when the count reaches their programmed value. Each pulse lasts one prescaled period, so it can start a converter sample or serve as a comparator window. The two pulses can also be merged onto one shared line.

After the count reaches the programmed modulus, the counter clears and a completion flag rises for one clock. In single-shot mode the block then waits for the next edge. In continuous mode it starts the next sequence at once. A bypass mode skips the counter entirely and passes the selected edge straight to both pulse outputs.

All settings are loaded through a small synchronous write port.

Top module: `trig_delay_top`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at the clock edge into the register chosen by `wr_addr`: 0 control, 1 modulus, 2 channel-A compare, 3 channel-B compare. The control fields are: bit 0 enable, bit 1 continuous, bit 2 bypass, bit 3 combine, bits 6:4 trigger select, bits 10:8 prescaler select.
- R2: Trigger select values 0 to 6 pick the matching bit of `trig_in`, and value 7 picks no trigger. Edges on trigger lines that are not selected have no effect.
- R3: A sequence starts only on a low-to-high change of the selected trigger while the block is enabled and not in bypass. The count is 0 after the starting edge. A trigger held high or low starts nothing, and an edge seen while the block is disabled starts nothing.
- R4: The prescaler divides by 2 to the power of the prescaler select (1 to 128). Each count value therefore lasts that many clocks.
- R5: `out_a` is high while a sequence runs and the count equals the channel-A compare, and `out_b` does the same for channel B. Each pulse lasts exactly one prescaled period. A compare value above the modulus produces no pulse.
- R6: In single-shot mode one edge yields one sequence. An edge that arrives during a running sequence is ignored.
- R7: In continuous mode a new sequence begins right after each one ends, with a period of (modulus+1) prescaled periods. Clearing the enable stops it.
- R8: When the count equals the modulus at the end of its period, the counter clears and `seq_done` is high for one clock. This happens (modulus+1) prescaled periods after the start.
- R9: With combine set, `out_or` is the OR of `out_a` and `out_b`. With combine clear, `out_or` stays low.
- R10: In bypass, a selected rising edge sets `out_a` and `out_b` high for the one clock before the edge is registered. The counter does not run and `seq_done` stays low.
- R11: Synchronous reset clears every register, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| trig_in | input | 7 | Hardware trigger lines |
| out_a | output | 1 | Channel-A delayed pulse |
| out_b | output | 1 | Channel-B delayed pulse |
| out_or | output | 1 | Merged pulse line |
| seq_done | output | 1 | One-clock sequence completion flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, seven trigger lines and a 3-bit prescaler select. This lets it program the widest divider (128) and a channel-B compare of 0xFFFF that lies above a small modulus. Prescaler settings of 1, 2, 4 and 128 are covered. Each expected pulse is scheduled from the start edge, with its start cycle and width. Retrigger edges, edges on unselected lines, steady trigger levels, and edges seen while disabled or with the select set to 7 must all produce no output.

// File: rtl/tdb_pkg.sv
package tdb_pkg;

    localparam int SEL_W  = 3;
    localparam int PS_W   = 3;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 11;
    localparam int PSC_W  = (1 << PS_W) - 1;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_MOD   = 2'd1,
        REG_DLY_A = 2'd2,
        REG_DLY_B = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [PS_W-1:0]  ps;
        logic [SEL_W-1:0] sel;
        logic             comb;
        logic             byp;
        logic             cont;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(logic [CTRL_W-1:0] w);
        ctrl_t c;
        c.en   = w[0];
        c.cont = w[1];
        c.byp  = w[2];
        c.comb = w[3];
        c.sel  = w[6:4];
        c.ps   = w[10:8];
        return c;
    endfunction

    function automatic logic [PSC_W-1:0] presc_limit(logic [PS_W-1:0] ps);
        logic [PSC_W-1:0] lim;
        lim = '0;
        for (int i = 0; i < PSC_W; i++) begin
            lim[i] = (i < int'(ps));
        end
        return lim;
    endfunction

endpackage

// File: rtl/tdb_regs.sv
module tdb_regs
    import tdb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [CNT_W-1:0]    wr_data,
    output ctrl_t               ctrl,
    output logic [CNT_W-1:0]    modv,
    output logic [CNT_W-1:0]    dly_a,
    output logic [CNT_W-1:0]    dly_b
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            modv  <= '0;
            dly_a <= '0;
            dly_b <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CTRL:  ctrl  <= decode_ctrl(wr_data[CTRL_W-1:0]);
                REG_MOD:   modv  <= wr_data;
                REG_DLY_A: dly_a <= wr_data;
                REG_DLY_B: dly_b <= wr_data;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/tdb_trig_sel.sv
module tdb_trig_sel
    import tdb_pkg::*;
#(
    parameter int N_TRIG = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRIG-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    output logic              rise
);

    logic cur;
    logic prev;

    always_comb begin
        cur = 1'b0;
        for (int i = 0; i < N_TRIG; i++) begin
            if (sel == SEL_W'(i)) cur = trig_in[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= cur;
    end

    assign rise = cur & ~prev;

    // R3: an edge indication never lasts two clocks
    p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/tdb_seq.sv
module tdb_seq
    import tdb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              byp,
    input  logic              cont,
    input  logic [PS_W-1:0]   ps,
    input  logic              start,
    input  logic [CNT_W-1:0]  modv,
    output logic              running,
    output logic [CNT_W-1:0]  cnt,
    output logic              done
);

    logic [PSC_W-1:0] pcnt;
    logic             tick;

    assign tick = running && (pcnt == presc_limit(ps));

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
            pcnt    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en || byp) begin
                running <= 1'b0;
                cnt     <= '0;
                pcnt    <= '0;
            end else if (!running) begin
                running <= start;
                cnt     <= '0;
                pcnt    <= '0;
            end else if (tick) begin
                pcnt <= '0;
                if (cnt == modv) begin
                    cnt     <= '0;
                    done    <= 1'b1;
                    running <= cont;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    // R4: the count holds between prescaler ticks
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (running && !tick && en && !byp) |=> $stable(cnt));

    // R6: a running sequence is never cut short by a new edge
    p_no_retrig_r6: assert property (@(posedge clk) disable iff (rst)
        (running && !tick && en && !byp) |=> running);

    // R8: completion coincides with a cleared counter
    p_clear_on_done_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == '0));

    // R3: a sequence only begins after a trigger edge
    p_start_edge_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(running) |-> $past(start));

    // R10: bypass keeps the counter idle
    p_bypass_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $past(byp) |-> !running);

endmodule

// File: rtl/tdb_out.sv
module tdb_out #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              byp,
    input  logic              comb,
    input  logic              rise,
    input  logic              running,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  dly_a,
    input  logic [CNT_W-1:0]  dly_b,
    output logic              out_a,
    output logic              out_b,
    output logic              out_or
);

    logic [1:0]             hit;
    logic [1:0][CNT_W-1:0]  dly;

    assign dly = {dly_b, dly_a};

    for (genvar g = 0; g < 2; g++) begin : g_chan
        assign hit[g] = byp ? (en & rise) : (running && (cnt == dly[g]));
    end

    assign out_a  = hit[0];
    assign out_b  = hit[1];
    assign out_or = comb & (hit[0] | hit[1]);

    // R9: the merged line never fires alone
    p_or_source_r9: assert property (@(posedge clk) disable iff (rst)
        out_or |-> (out_a || out_b));

endmodule

// File: rtl/trig_delay_top.sv
module trig_delay_top
    import tdb_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int N_TRIG = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [N_TRIG-1:0] trig_in,
    output logic              out_a,
    output logic              out_b,
    output logic              out_or,
    output logic              seq_done
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] modv;
    logic [CNT_W-1:0] dly_a;
    logic [CNT_W-1:0] dly_b;
    logic             rise;
    logic             running;
    logic [CNT_W-1:0] cnt;

    tdb_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .modv    (modv),
        .dly_a   (dly_a),
        .dly_b   (dly_b)
    );

    tdb_trig_sel #(.N_TRIG(N_TRIG)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .trig_in (trig_in),
        .sel     (ctrl.sel),
        .rise    (rise)
    );

    tdb_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.en),
        .byp     (ctrl.byp),
        .cont    (ctrl.cont),
        .ps      (ctrl.ps),
        .start   (rise),
        .modv    (modv),
        .running (running),
        .cnt     (cnt),
        .done    (seq_done)
    );

    tdb_out #(.CNT_W(CNT_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl.en),
        .byp     (ctrl.byp),
        .comb    (ctrl.comb),
        .rise    (rise),
        .running (running),
        .cnt     (cnt),
        .dly_a   (dly_a),
        .dly_b   (dly_b),
        .out_a   (out_a),
        .out_b   (out_b),
        .out_or  (out_or)
    );

endmodule

// File: tb/trig_delay_top_tb_top.sv
module trig_delay_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [6:0]  trig_in = '0;
    logic        out_a, out_b, out_or, seq_done;

    always #4 clk = ~clk;

    trig_delay_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .out_a(out_a),
        .out_b(out_b), .out_or(out_or), .seq_done(seq_done)
    );

    typedef struct { int s; int w; string tag; } ev_t;

    ev_t   expq [4][$];
    string kname [4] = '{"R5 out_a", "R5 out_b", "R9 out_or", "R8 seq_done"};
    int    cyc = 0;
    int    checks = 0, errors = 0, unexp = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic expect_ev(int k, int s, int w, string tag);
        ev_t e;
        e.s = s; e.w = w; e.tag = tag;
        expq[k].push_back(e);
    endtask

    // scoreboard monitor: samples 6 ns after each rising edge
    initial begin
        logic [3:0] pv;
        int         st [4];
        pv = '0;
        forever begin
            logic [3:0] v;
            @(posedge clk);
            #6;
            v = {seq_done, out_or, out_b, out_a};
            for (int k = 0; k < 4; k++) begin
                if (v[k] && !pv[k]) st[k] = cyc;
                else if (!v[k] && pv[k]) begin
                    if (expq[k].size() == 0) begin
                        unexp++;
                        check(1'b0, {kname[k], " unexpected pulse at cycle"}, st[k], -1);
                    end else begin
                        ev_t e;
                        e = expq[k].pop_front();
                        check(e.s == st[k], {e.tag, " start"}, st[k], e.s);
                        check(e.w == cyc - st[k], {e.tag, " width"}, cyc - st[k], e.w);
                    end
                end
            end
            pv = v;
        end
    end

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int ctrlw(int en, int cont, int byp, int comb, int sel, int ps);
        return (ps << 8) | (sel << 4) | (comb << 3) | (byp << 2) | (cont << 1) | en;
    endfunction

    task automatic exp_seq(int e, int d, int m, int a, int b, int comb, int n);
        for (int k = 0; k < n; k++) begin
            int base;
            base = e + k * (m + 1) * d;
            if (a <= m) expect_ev(0, base + a * d, d, "R5 channel A");
            if (b <= m) expect_ev(1, base + b * d, d, "R5 channel B");
            if (comb != 0) begin
                int lo, hi;
                lo = (a < b) ? a : b;
                hi = (a < b) ? b : a;
                if (lo <= m) expect_ev(2, base + lo * d, d, "R9 merged");
                if (hi != lo && hi <= m) expect_ev(2, base + hi * d, d, "R9 merged");
            end
            expect_ev(3, base + (m + 1) * d, 1, "R8 completion");
        end
    endtask

    task automatic drained(string tag);
        int pend;
        pend = 0;
        for (int k = 0; k < 4; k++) pend += expq[k].size();
        check(pend == 0, {tag, " pending expected pulses"}, pend, 0);
        check(unexp == 0, {tag, " unexpected pulses"}, unexp, 0);
        for (int k = 0; k < 4; k++) expq[k].delete();
        unexp = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int e;
        idle(3);
        // R11: outputs low during reset
        check({out_a, out_b, out_or, seq_done} == 4'b0, "R11 reset outputs",
              {out_a, out_b, out_or, seq_done}, 0);
        rst = 1'b0;
        idle(3);
        check({out_a, out_b, out_or, seq_done} == 4'b0, "R11 idle after reset",
              {out_a, out_b, out_or, seq_done}, 0);

        // R1 R3 R5 R8 R9: single-shot, divide by 1, trigger held high afterwards
        wr(1, 5); wr(2, 1); wr(3, 4);
        wr(0, ctrlw(1, 0, 0, 1, 3, 0));
        trig_in[3] = 1'b1; e = cyc + 1;
        exp_seq(e, 1, 5, 1, 4, 1, 1);
        idle(40);
        drained("R3 steady high level");
        trig_in = '0; idle(3);

        // R4 R6 R2: divide by 4, retrigger and unselected edge ignored
        wr(1, 6); wr(2, 2); wr(3, 2);
        wr(0, ctrlw(1, 0, 0, 0, 5, 2));
        trig_in[5] = 1'b1; e = cyc + 1;
        exp_seq(e, 4, 6, 2, 2, 0, 1);
        idle(5);
        trig_in[5] = 1'b0; trig_in[2] = 1'b1;
        idle(2);
        trig_in[5] = 1'b1;
        idle(40);
        drained("R6 retrigger ignored");
        trig_in = '0; idle(3);

        // R7: continuous, divide by 2, three sequences then disable
        wr(1, 3); wr(2, 1); wr(3, 3);
        wr(0, ctrlw(1, 1, 0, 1, 0, 1));
        trig_in[0] = 1'b1; e = cyc + 1;
        exp_seq(e, 2, 3, 1, 3, 1, 3);
        idle(2);
        trig_in[0] = 1'b0;
        while (cyc < e + 24) @(negedge clk);
        wr(0, ctrlw(0, 1, 0, 1, 0, 1));
        idle(30);
        drained("R7 continuous restart and stop");

        // R10: bypass passes the edge through
        wr(0, ctrlw(1, 0, 1, 1, 1, 0));
        trig_in[1] = 1'b1; e = cyc + 1;
        expect_ev(0, e - 1, 1, "R10 bypass A");
        expect_ev(1, e - 1, 1, "R10 bypass B");
        expect_ev(2, e - 1, 1, "R10 bypass merged");
        idle(12);
        drained("R10 bypass no delayed pulse");
        trig_in = '0; idle(3);

        // R3: disabled block ignores edge; R2: select 7 picks nothing
        wr(0, ctrlw(0, 0, 0, 1, 3, 0));
        trig_in[3] = 1'b1;
        idle(20);
        drained("R3 disabled edge");
        trig_in = '0; idle(2);
        wr(0, ctrlw(1, 0, 0, 1, 7, 0));
        trig_in = 7'h7f;
        idle(20);
        drained("R2 select none");
        trig_in = '0; idle(3);

        // R4 R5: divide by 128, channel B compare above modulus never fires
        wr(1, 1); wr(2, 1); wr(3, 16'hFFFF);
        wr(0, ctrlw(1, 0, 0, 0, 6, 7));
        trig_in[6] = 1'b1; e = cyc + 1;
        exp_seq(e, 128, 1, 1, 65535, 0, 1);
        idle(300);
        drained("R4 divide by 128");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule